// File: doc/BRIEF.md
# Signed-Digit Modular Multiplier

This block multiplies two N-digit radix-2 signed-digit operands and returns their product as an N-digit signed-digit residue. The modulus is fixed at elaboration by a parameter and is one of 2^N−1, 2^N or 2^N+1. The block is purely combinational. It is meant to serve as a residue-channel multiplier inside a residue arithmetic datapath. Because the digits are redundant, no carry travels further than one digit position at any stage.

The multiplier digits are taken in adjacent pairs. Each pair selects one multiple of the multiplicand from the set {0, ±x, ±2x, ±3x}. The ±2x multiple comes from a one-digit modular rotation. The ±3x multiple is made once, with a single modular adder. Negation only swaps the two bits of each digit. Each selected multiple is weighted by 4^i through a modular digit rotation. The N/2 weighted terms are then summed in a balanced binary tree of identical N-digit carry-free modular adders. The result is congruent to the product, but its digit pattern need not be the canonical one. For modulus 2^N+1 it may use the negative range.

Top module: `sd_mod_mult`

## Requirements
- R1: Each digit occupies two bits. Bit 2i is the positive flag and bit 2i+1 is the negative flag, so 00 is 0, 01 is +1 and 10 is −1. The code 11 never appears on p_o when both operands use only legal codes.
- R2: With MODE = MOD_MINUS1, value(p_o) ≡ value(x_i)·value(y_i) (mod 2^N−1).
- R3: With MODE = MOD_POW2, value(p_o) ≡ value(x_i)·value(y_i) (mod 2^N).
- R4: With MODE = MOD_PLUS1, value(p_o) ≡ value(x_i)·value(y_i) (mod 2^N+1).
- R5: Multiplier digits 2i (low, y_i bits 4i+1:4i) and 2i+1 (high) form one pair. The product is correct when a single pair holds any of the nine legal digit combinations, including (high −1, low −1) = −3 and (high +1, low −1) = +1, with every other digit zero.
- R6: When either operand is all zero digits, p_o is all zero bits.
- R7: The product is correct when both operands are all +1 digits, all −1 digits, or one of each.
- R8: With MODE = MOD_POW2, digit 0 of p_o is nonzero exactly when digit 0 of x_i and digit 0 of y_i are both nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 2*N | Multiplicand, N signed digits, two bits each |
| y_i | input | 2*N | Multiplier, N signed digits, two bits each |
| p_o | output | 2*N | Residue of the product, N signed digits |

## Verification
The assertions assume that every operand digit carries one of the three legal codes, never 11, and they stay silent while any input or output bit is unknown. The bench draws each random digit uniformly from the three legal codes only. Its directed operands are built from the same codes: single active pairs, all +1 and all −1 words, and zero words. The 11 code therefore never reaches the design.

// File: rtl/sd_mod_pkg.sv
package sd_mod_pkg;

  typedef enum logic [1:0] {
    MOD_MINUS1 = 2'd0,
    MOD_POW2   = 2'd1,
    MOD_PLUS1  = 2'd2
  } sd_mod_e;

  // bit0 = positive flag, bit1 = negative flag
  function automatic logic signed [2:0] dig_val(input logic [1:0] d);
    logic signed [2:0] r;
    r = 3'sd0;
    if (d == 2'b01) r = 3'sd1;
    else if (d == 2'b10) r = -3'sd1;
    return r;
  endfunction

  function automatic logic [1:0] dig_enc(input logic signed [2:0] v);
    logic [1:0] r;
    r = 2'b00;
    if (v > 3'sd0) r = 2'b01;
    else if (v < 3'sd0) r = 2'b10;
    return r;
  endfunction

  // up: incoming carry known to lie in {0,+1}
  function automatic logic signed [2:0] carry_of(input logic signed [2:0] w, input logic up);
    logic signed [2:0] c;
    c = 3'sd0;
    if (w == 3'sd2) c = 3'sd1;
    else if (w == 3'sd1) c = up ? 3'sd1 : 3'sd0;
    else if (w == -3'sd1) c = up ? 3'sd0 : -3'sd1;
    else if (w == -3'sd2) c = -3'sd1;
    return c;
  endfunction

endpackage

// File: rtl/sd_mod_add.sv
module sd_mod_add
  import sd_mod_pkg::*;
#(
  parameter int      N    = 8,
  parameter sd_mod_e MODE = MOD_MINUS1
) (
  input  logic [2*N-1:0] a_i,
  input  logic [2*N-1:0] b_i,
  output logic [2*N-1:0] s_o
);

  logic [N-1:0]      nn;
  logic signed [2:0] wsum [N];
  logic signed [2:0] cgen [N];
  logic signed [2:0] cwrap;
  logic              up0;

  for (genvar i = 0; i < N; i++) begin : g_dig
    assign nn[i]   = ~a_i[2*i+1] & ~b_i[2*i+1];
    assign wsum[i] = dig_val(a_i[2*i +: 2]) + dig_val(b_i[2*i +: 2]);
    if (i == 0) begin : g_lsd
      assign cgen[i] = carry_of(wsum[i], up0);
    end else begin : g_up
      assign cgen[i] = carry_of(wsum[i], nn[i-1]);
    end
  end

  // end-around carry per modulus
  if (MODE == MOD_MINUS1) begin : g_wrap_m1
    assign up0   = nn[N-1];
    assign cwrap = cgen[N-1];
  end else if (MODE == MOD_PLUS1) begin : g_wrap_p1
    assign up0   = ~nn[N-1];
    assign cwrap = -cgen[N-1];
  end else begin : g_wrap_p0
    assign up0   = 1'b1;
    assign cwrap = 3'sd0;
  end

  for (genvar i = 0; i < N; i++) begin : g_sum
    logic signed [2:0] cin;
    logic signed [2:0] u_dig;
    if (i == 0) begin : g_c0
      assign cin = cwrap;
    end else begin : g_ci
      assign cin = cgen[i-1];
    end
    assign u_dig          = wsum[i] - (cgen[i] <<< 1);
    assign s_o[2*i +: 2]  = dig_enc(u_dig + cin);
  end

endmodule

// File: rtl/sd_mod_scale.sv
module sd_mod_scale
  import sd_mod_pkg::*;
#(
  parameter int      N    = 8,
  parameter sd_mod_e MODE = MOD_MINUS1,
  parameter int      SH   = 0
) (
  input  logic [2*N-1:0] d_i,
  output logic [2*N-1:0] d_o
);

  // multiply by 2^SH: wrapped digits kept, dropped or negated
  for (genvar j = 0; j < N; j++) begin : g_pos
    if (j >= SH) begin : g_keep
      assign d_o[2*j +: 2] = d_i[2*(j-SH) +: 2];
    end else if (MODE == MOD_MINUS1) begin : g_rot
      assign d_o[2*j +: 2] = d_i[2*(N-SH+j) +: 2];
    end else if (MODE == MOD_PLUS1) begin : g_rotn
      assign d_o[2*j +: 2] = {d_i[2*(N-SH+j)], d_i[2*(N-SH+j)+1]};
    end else begin : g_zero
      assign d_o[2*j +: 2] = 2'b00;
    end
  end

endmodule

// File: rtl/sd_mod_ppsel.sv
module sd_mod_ppsel
  import sd_mod_pkg::*;
#(
  parameter int      N    = 8,
  parameter sd_mod_e MODE = MOD_MINUS1,
  parameter int      SH   = 0
) (
  input  logic [2*N-1:0] x1_i,
  input  logic [2*N-1:0] x2_i,
  input  logic [2*N-1:0] x3_i,
  input  logic [3:0]     pair_i,
  output logic [2*N-1:0] pp_o
);

  logic [2*N-1:0] mag;
  logic [2*N-1:0] mag_neg;
  logic [2*N-1:0] rp;
  logic           neg;

  // pair_i = {high digit, low digit}; value = 2*high + low
  always_comb begin
    mag = '0;
    neg = 1'b0;
    case (pair_i)
      4'b0001: mag = x1_i;
      4'b0010: begin mag = x1_i; neg = 1'b1; end
      4'b0100: mag = x2_i;
      4'b0101: mag = x3_i;
      4'b0110: mag = x1_i;
      4'b1000: begin mag = x2_i; neg = 1'b1; end
      4'b1001: begin mag = x1_i; neg = 1'b1; end
      4'b1010: begin mag = x3_i; neg = 1'b1; end
      default: mag = '0;
    endcase
  end

  for (genvar j = 0; j < N; j++) begin : g_neg
    assign mag_neg[2*j +: 2] = {mag[2*j], mag[2*j+1]};
  end

  assign rp = neg ? mag_neg : mag;

  sd_mod_scale #(.N(N), .MODE(MODE), .SH(SH)) u_wt (
    .d_i(rp),
    .d_o(pp_o)
  );

endmodule

// File: rtl/sd_mod_tree.sv
module sd_mod_tree
  import sd_mod_pkg::*;
#(
  parameter int      N     = 8,
  parameter sd_mod_e MODE  = MOD_MINUS1,
  parameter int      NLEAF = 4
) (
  input  logic [NLEAF*2*N-1:0] leaf_i,
  output logic [2*N-1:0]       sum_o
);

  localparam int W  = 2 * N;
  localparam int LV = (NLEAF <= 1) ? 1 : (1 << $clog2(NLEAF));

  // heap layout: node 0 is the root, leaves at LV-1 ..
  logic [W-1:0] node [2*LV-1];

  for (genvar k = 0; k < LV; k++) begin : g_leaf
    if (k < NLEAF) begin : g_used
      assign node[LV-1+k] = leaf_i[k*W +: W];
    end else begin : g_pad
      assign node[LV-1+k] = '0;
    end
  end

  for (genvar k = 0; k < LV - 1; k++) begin : g_node
    sd_mod_add #(.N(N), .MODE(MODE)) u_add (
      .a_i(node[2*k+1]),
      .b_i(node[2*k+2]),
      .s_o(node[k])
    );
  end

  assign sum_o = node[0];

endmodule

// File: rtl/sd_mod_mult.sv
module sd_mod_mult
  import sd_mod_pkg::*;
#(
  parameter int      N    = 8,
  parameter sd_mod_e MODE = MOD_MINUS1
) (
  input  logic [2*N-1:0] x_i,
  input  logic [2*N-1:0] y_i,
  output logic [2*N-1:0] p_o
);

  localparam int W   = 2 * N;
  localparam int NPP = N / 2;

  logic [W-1:0]     x_dbl;
  logic [W-1:0]     x_tri;
  logic [NPP*W-1:0] pp_flat;

  sd_mod_scale #(.N(N), .MODE(MODE), .SH(1)) u_dbl (
    .d_i(x_i),
    .d_o(x_dbl)
  );

  sd_mod_add #(.N(N), .MODE(MODE)) u_tri (
    .a_i(x_dbl),
    .b_i(x_i),
    .s_o(x_tri)
  );

  for (genvar i = 0; i < NPP; i++) begin : g_pp
    sd_mod_ppsel #(.N(N), .MODE(MODE), .SH(2*i)) u_pp (
      .x1_i  (x_i),
      .x2_i  (x_dbl),
      .x3_i  (x_tri),
      .pair_i(y_i[4*i +: 4]),
      .pp_o  (pp_flat[i*W +: W])
    );
  end

  sd_mod_tree #(.N(N), .MODE(MODE), .NLEAF(NPP)) u_tree (
    .leaf_i(pp_flat),
    .sum_o (p_o)
  );

endmodule

// File: rtl/sd_mod_mult_chk.sv
module sd_mod_mult_chk
  import sd_mod_pkg::*;
#(
  parameter int      N    = 8,
  parameter sd_mod_e MODE = MOD_MINUS1
) (
  input logic [2*N-1:0] x_i,
  input logic [2*N-1:0] y_i,
  input logic [2*N-1:0] p_o
);

  localparam longint M = (MODE == MOD_MINUS1) ? ((longint'(1) << N) - 1) :
                         (MODE == MOD_PLUS1)  ? ((longint'(1) << N) + 1) :
                                                 (longint'(1) << N);

  function automatic longint val(input logic [2*N-1:0] v);
    longint r;
    r = 0;
    for (int j = 0; j < N; j++) begin
      if (v[2*j])   r = r + (longint'(1) << j);
      if (v[2*j+1]) r = r - (longint'(1) << j);
    end
    return r;
  endfunction

  function automatic longint resid(input longint v);
    longint r;
    r = v % M;
    if (r < 0) r = r + M;
    return r;
  endfunction

  function automatic bit legal(input logic [2*N-1:0] v);
    bit ok;
    ok = 1'b1;
    for (int j = 0; j < N; j++) if (v[2*j +: 2] == 2'b11) ok = 1'b0;
    return ok;
  endfunction

  logic known;
  logic in_ok;
  assign known = !$isunknown({x_i, y_i, p_o});
  assign in_ok = known && legal(x_i) && legal(y_i);

  always_comb begin
    if (in_ok) begin
      assert_digit_code_R1: assert (legal(p_o));
      if (x_i == '0 || y_i == '0)
        assert_zero_operand_R6: assert (p_o == '0);
      if (y_i == {{(2*N-2){1'b0}}, 2'b01})
        assert_unit_multiplier_R5: assert (resid(val(p_o)) == resid(val(x_i)));
    end
  end

  if (MODE == MOD_MINUS1) begin : g_m1
    always_comb if (in_ok)
      assert_residue_R2: assert (resid(val(p_o)) == resid(val(x_i) * val(y_i)));
  end else if (MODE == MOD_POW2) begin : g_p0
    always_comb if (in_ok) begin
      assert_residue_R3: assert (resid(val(p_o)) == resid(val(x_i) * val(y_i)));
      assert_low_digit_R8: assert ((p_o[1:0] != 2'b00) == ((x_i[1:0] != 2'b00) && (y_i[1:0] != 2'b00)));
    end
  end else begin : g_p1
    always_comb if (in_ok)
      assert_residue_R4: assert (resid(val(p_o)) == resid(val(x_i) * val(y_i)));
  end

endmodule

bind sd_mod_mult sd_mod_mult_chk #(.N(N), .MODE(MODE)) u_chk (
  .x_i(x_i),
  .y_i(y_i),
  .p_o(p_o)
);

// File: tb/sim_sd_mod_mult.sv
module sim_sd_mod_mult;
  import sd_mod_pkg::*;

  localparam int N = 8;
  localparam int W = 2 * N;
  localparam longint M_M1 = (longint'(1) << N) - 1;
  localparam longint M_P0 = (longint'(1) << N);
  localparam longint M_P1 = (longint'(1) << N) + 1;

  logic clk = 1'b0;
  logic rst_ni;
  always #5 clk = ~clk;

  logic [W-1:0] x, y;
  logic [W-1:0] p_m1, p_p0, p_p1;

  sd_mod_mult #(.N(N), .MODE(MOD_MINUS1)) u0 (.x_i(x), .y_i(y), .p_o(p_m1));
  sd_mod_mult #(.N(N), .MODE(MOD_POW2))   u1 (.x_i(x), .y_i(y), .p_o(p_p0));
  sd_mod_mult #(.N(N), .MODE(MOD_PLUS1))  u2 (.x_i(x), .y_i(y), .p_o(p_p1));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  function automatic longint val(input logic [W-1:0] v);
    longint r;
    r = 0;
    for (int j = 0; j < N; j++) begin
      if (v[2*j])   r = r + (longint'(1) << j);
      if (v[2*j+1]) r = r - (longint'(1) << j);
    end
    return r;
  endfunction

  function automatic longint modr(input longint v, input longint m);
    longint r;
    r = v % m;
    if (r < 0) r = r + m;
    return r;
  endfunction

  function automatic logic [1:0] rnd_dig();
    logic [1:0] d;
    case ($urandom % 3)
      0:       d = 2'b00;
      1:       d = 2'b01;
      default: d = 2'b10;
    endcase
    return d;
  endfunction

  function automatic logic [W-1:0] rnd_sd();
    logic [W-1:0] v;
    for (int j = 0; j < N; j++) v[2*j +: 2] = rnd_dig();
    return v;
  endfunction

  function automatic bit legal(input logic [W-1:0] v);
    bit ok;
    ok = 1'b1;
    for (int j = 0; j < N; j++) if (v[2*j +: 2] == 2'b11) ok = 1'b0;
    return ok;
  endfunction

  task automatic apply(input logic [W-1:0] xv, input logic [W-1:0] yv);
    @(negedge clk);
    x = xv;
    y = yv;
    #1;
  endtask

  task automatic chk_res(input string tag, input logic [W-1:0] p, input longint m);
    longint got, exp;
    n_chk++;
    got = modr(val(p), m);
    exp = modr(val(x) * val(y), m);
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s x=%h y=%h actual %0d expected %0d", tag, x, y, got, exp);
    end
  endtask

  task automatic chk_codes(input logic [W-1:0] p);
    n_chk++;
    if (!legal(p)) begin
      n_fail++;
      $display("FAIL R1 illegal digit code: actual %h expected no 11 pair", p);
    end
  endtask

  task automatic chk_all(input string tag);
    chk_res({tag, " R2"}, p_m1, M_M1);
    chk_res({tag, " R3"}, p_p0, M_P0);
    chk_res({tag, " R4"}, p_p1, M_P1);
  endtask

  task automatic chk_zero(input string tag);
    n_chk++;
    if (p_m1 != '0 || p_p0 != '0 || p_p1 != '0) begin
      n_fail++;
      $display("FAIL %s actual %h/%h/%h expected 0", tag, p_m1, p_p0, p_p1);
    end
  endtask

  task automatic chk_low_r8();
    bit got, exp;
    n_chk++;
    got = (p_p0[1:0] != 2'b00);
    exp = (x[1:0] != 2'b00) && (y[1:0] != 2'b00);
    if (got != exp) begin
      n_fail++;
      $display("FAIL R8 low digit x=%h y=%h actual %0b expected %0b", x, y, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired, run incomplete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ones_p, ones_n;
    void'($urandom(32'd1234));
    ones_p = {N{2'b01}};
    ones_n = {N{2'b10}};
    x = '0;
    y = '0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk_zero("R6 reset state");
    rst_ni = 1'b1;

    // R6: one operand zero
    for (int k = 0; k < 4; k++) begin
      apply(rnd_sd(), '0);
      chk_zero("R6 y zero");
      apply('0, rnd_sd());
      chk_zero("R6 x zero");
    end

    // R7: uniform operands
    apply(ones_p, ones_p); chk_all("R7 +1*+1");
    apply(ones_n, ones_n); chk_all("R7 -1*-1");
    apply(ones_p, ones_n); chk_all("R7 +1*-1");
    apply(ones_n, ones_p); chk_all("R7 -1*+1");

    // R5: each pair position, each digit combination
    for (int k = 0; k < N / 2; k++) begin
      for (int hi = 0; hi < 3; hi++) begin
        for (int lo = 0; lo < 3; lo++) begin
          logic [W-1:0] yv;
          logic [1:0]   dh, dl;
          dh = (hi == 0) ? 2'b00 : (hi == 1) ? 2'b01 : 2'b10;
          dl = (lo == 0) ? 2'b00 : (lo == 1) ? 2'b01 : 2'b10;
          yv = '0;
          yv[4*k +: 4] = {dh, dl};
          apply(rnd_sd(), yv);
          chk_all("R5 pair");
          apply(ones_n, yv);
          chk_all("R5 pair all -1 x");
        end
      end
    end

    // R2 R3 R4 R1 R8: random operands
    for (int k = 0; k < 400; k++) begin
      apply(rnd_sd(), rnd_sd());
      chk_all("random");
      chk_codes(p_m1);
      chk_codes(p_p0);
      chk_codes(p_p1);
      chk_low_r8();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule